// File: doc/BRIEF.md
# Glitch-Free Clock Source Selector

This block picks which of five free-running clocks drives one clock domain. Software writes a 3-bit select code into a configuration register in the register clock domain. The selector then moves the output from the old clock to the new one without producing a runt pulse. It first gates the old clock off on that clock's own falling edge. Only after that shutdown has been seen back in the register domain does it enable the new clock, again on the new clock's own falling edge.

While a change is under way, a read-only busy flag in the same register reads 1. Software polls this flag until it reads 0, and from then on the output is driven by the requested source. The five sources are:

- 0: system oscillator
- 1: slow real-time oscillator
- 2, 3, 4: the three PLL outputs

Codes 5 to 7 are rejected. The upper register bits are plain storage that a read returns. This lets software do read-modify-write without disturbing the select field.

Each source has its own enable lane. The lane passes its request through a two-flop synchronizer clocked by that source and ends in a falling-edge gate flop. Each gate state is synchronized back into the register domain. That returned status drives both the interlock between lanes and the clearing of busy.

Top module: `clk_src_select`

## Requirements
- R1: During and after a synchronous reset, rd_data[2:0] reads 0 and rd_data[3] (busy) reads 0, and clk_out follows src_clk[0].
- R2: Select code k in 0..4 routes src_clk[k] to clk_out. Once busy reads 0 after a change to k, clk_out equals src_clk[k].
- R3: rd_data[2:0] is the active select code and rd_data[3] is busy. Bits [31:4] return bits [31:4] of the last write. The value written to bit 3 has no effect.
- R4: A write whose code is valid and differs from the active code, made while busy is 0, makes rd_data[3] read 1 and rd_data[2:0] read the new code on the cycle after the write.
- R5: A write of the code already active leaves busy at 0 and the code unchanged.
- R6: A write of code 5, 6 or 7 leaves the active code and clk_out unchanged and does not set busy. Bits [31:4] are still stored.
- R7: A select write made while busy is 1 does not change the select code. Its bits [31:4] are still stored.
- R8: At most one source gate is open at any time. No high or low phase of clk_out is shorter than the shortest half period among the sources.
- R9: Busy clears only after the register domain has seen the new source's gate open and every other gate closed.
- R10: Every accepted change completes, and busy returns to 0 within a bounded number of register-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-domain clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of the slowest source |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value: select, busy, stored upper bits |
| src_clk | input | 5 | Candidate source clocks, index equals select code |
| clk_out | output | 1 | Selected, glitch-free domain clock |

## Verification
The bench builds the block with its default parameters: five sources, two synchronizer stages and a 32-bit register. It drives the sources at five unrelated even half periods, with the real-time source far slower than the rest. At this size every pair of start code (0..4) and written code (0..7) can be swept, including same-code and invalid writes. The case of a new write landing during a switch is also covered. A pulse-width monitor on clk_out runs across the entire sweep, so each of the twenty real transitions is screened for a runt phase.

// File: rtl/clk_src_select_pkg.sv
package clk_src_select_pkg;

    localparam int DEF_NUM_SRC     = 5;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int DEF_DATA_W      = 32;

    // Names of the source slots; the numeric value is the select code.
    typedef enum logic [2:0] {
        SRC_SYS_OSC = 3'd0,
        SRC_RTC_OSC = 3'd1,
        SRC_PLL_A   = 3'd2,
        SRC_PLL_B   = 3'd3,
        SRC_PLL_C   = 3'd4
    } src_id_e;

    // Width of a select field able to name n sources.
    function automatic int sel_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // True when a select code names an existing source.
    function automatic logic sel_valid(input int unsigned code, input int unsigned n);
        return code < n;
    endfunction

endpackage

// File: rtl/clk_src_select_sync.sv
// Multi-flop level synchronizer with a selectable reset value.
module clk_src_select_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clk_src_select_lane.sv
// One source lane: request synchronized on the source's rising edge,
// gate updated on its falling edge so it only moves while the clock is low.
module clk_src_select_lane #(
    parameter int IDX         = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic rst,
    input  logic en_req,
    output logic gate
);
    localparam logic RST_ON = (IDX == 0);

    logic req_sync;

    clk_src_select_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(RST_ON)
    ) req_sync_i (
        .clk(src_clk),
        .rst(rst),
        .d  (en_req),
        .q  (req_sync)
    );

    always_ff @(negedge src_clk) begin
        if (rst) begin
            gate <= RST_ON;
        end else begin
            gate <= req_sync;
        end
    end
endmodule

// File: rtl/clk_src_select_grant.sv
// Interlock: a lane may be requested only when it is the target and
// every other lane is reported closed.
module clk_src_select_grant #(
    parameter int NUM_SRC = 5,
    parameter int SEL_W   = 3
) (
    input  logic [SEL_W-1:0]   target,
    input  logic [NUM_SRC-1:0] st,
    output logic [NUM_SRC-1:0] en_req
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_req
        logic [NUM_SRC-1:0] others;
        assign others    = st & ~(NUM_SRC'(1) << i);
        assign en_req[i] = (32'(target) == i) && (others == '0);
    end
endmodule

// File: rtl/clk_src_select_ctrl.sv
// Register-domain control: configuration storage, target code, busy flag.
module clk_src_select_ctrl
    import clk_src_select_pkg::*;
#(
    parameter int NUM_SRC = 5,
    parameter int SEL_W   = 3,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [NUM_SRC-1:0] st,
    output logic [SEL_W-1:0]   target,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int BUSY_POS = SEL_W;
    localparam logic [DATA_W-1:0] KEEP_MASK =
        {{(DATA_W-BUSY_POS-1){1'b1}}, {(BUSY_POS+1){1'b0}}};

    logic [SEL_W-1:0]   target_q;
    logic               busy_q;
    logic [DATA_W-1:0]  hold_q;
    logic [SEL_W-1:0]   wr_sel;
    logic               code_ok;
    logic               accept;
    logic [NUM_SRC-1:0] tgt_onehot;
    logic               settled;

    assign wr_sel  = wr_data[SEL_W-1:0];
    assign code_ok = sel_valid(32'(wr_sel), NUM_SRC);
    assign accept  = wr_en && !busy_q && code_ok && (wr_sel != target_q);

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            tgt_onehot[i] = (32'(target_q) == i);
        end
    end

    // Only the target lane open, every other lane seen closed.
    assign settled = (st == tgt_onehot);

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= '0;
            busy_q   <= 1'b0;
            hold_q   <= '0;
        end else begin
            if (wr_en) begin
                hold_q <= wr_data & KEEP_MASK;
            end
            if (accept) begin
                target_q <= wr_sel;
                busy_q   <= 1'b1;
            end else if (busy_q && settled) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign target  = target_q;
    assign rd_data = hold_q | DATA_W'({busy_q, target_q});
endmodule

// File: rtl/clk_src_select.sv
module clk_src_select
    import clk_src_select_pkg::*;
#(
    parameter int NUM_SRC     = DEF_NUM_SRC,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int DATA_W      = DEF_DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_SRC-1:0] src_clk,
    output logic               clk_out
);
    localparam int SEL_W = sel_width(NUM_SRC);

    logic [SEL_W-1:0]   target;
    logic [NUM_SRC-1:0] st;
    logic [NUM_SRC-1:0] en_req;
    logic [NUM_SRC-1:0] gate;

    clk_src_select_ctrl #(
        .NUM_SRC(NUM_SRC),
        .SEL_W  (SEL_W),
        .DATA_W (DATA_W)
    ) ctrl_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .st     (st),
        .target (target),
        .rd_data(rd_data)
    );

    clk_src_select_grant #(
        .NUM_SRC(NUM_SRC),
        .SEL_W  (SEL_W)
    ) grant_i (
        .target(target),
        .st    (st),
        .en_req(en_req)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
        clk_src_select_lane #(
            .IDX        (i),
            .SYNC_STAGES(SYNC_STAGES)
        ) lane_i (
            .src_clk(src_clk[i]),
            .rst    (rst),
            .en_req (en_req[i]),
            .gate   (gate[i])
        );

        clk_src_select_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(i == 0)
        ) st_sync_i (
            .clk(clk),
            .rst(rst),
            .d  (gate[i]),
            .q  (st[i])
        );
    end

    assign clk_out = |(src_clk & gate);
endmodule

// File: rtl/clk_src_select_chk.sv
module clk_src_select_chk #(
    parameter int NUM_SRC = 5,
    parameter int SEL_W   = 3,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [SEL_W-1:0]   wr_sel,
    input logic [DATA_W-1:0]  rd_data,
    input logic [NUM_SRC-1:0] gate,
    input logic [NUM_SRC-1:0] st
);
    logic [SEL_W-1:0] cur;
    logic             busy;
    logic             code_ok;
    logic             cur_seen;

    assign cur      = rd_data[SEL_W-1:0];
    assign busy     = rd_data[SEL_W];
    assign code_ok  = (32'(wr_sel) < NUM_SRC);
    assign cur_seen = ((st >> cur) & NUM_SRC'(1)) != '0;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cur == '0) && !busy);

    assert_busy_set_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && code_ok && (wr_sel != cur)) |=> busy && (cur == $past(wr_sel)));

    assert_same_code_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && (wr_sel == cur)) |=> !busy && $stable(cur));

    assert_invalid_code_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && !code_ok) |=> !busy && $stable(cur));

    assert_busy_write_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cur));

    assert_one_gate_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate));

    assert_done_seen_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> cur_seen && $onehot0(st));
endmodule

bind clk_src_select clk_src_select_chk #(
    .NUM_SRC(NUM_SRC),
    .SEL_W  (SEL_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_sel (wr_data[SEL_W-1:0]),
    .rd_data(rd_data),
    .gate   (gate),
    .st     (st)
);

// File: tb/clk_src_select_tb_top.sv
module clk_src_select_tb_top;
    localparam int CLK_PERIOD = 20;
    localparam int NSRC       = 5;
    localparam int MIN_HALF   = 6;
    localparam int POLL_LIMIT = 1000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [31:0]     wr_data = '0;
    logic [31:0]     rd_data;
    logic [NSRC-1:0] src_clk = '0;
    logic            clk_out;

    int checks = 0;
    int errors = 0;
    int glitches = 0;
    int out_edges = 0;
    bit done = 0;
    longint last_edge = 0;

    clk_src_select dut_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .src_clk(src_clk),
        .clk_out(clk_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always #14 src_clk[0] = ~src_clk[0];
    always #46 src_clk[1] = ~src_clk[1];
    always #6  src_clk[2] = ~src_clk[2];
    always #8  src_clk[3] = ~src_clk[3];
    always #12 src_clk[4] = ~src_clk[4];

    // Runt-pulse monitor on the output (R8).
    always @(clk_out) begin
        if (!rst) begin
            if (out_edges > 0 && ($time - last_edge) < MIN_HALF) glitches++;
            out_edges++;
        end
        last_edge = $time;
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Drive one write at a negedge; returns at the next negedge.
    task automatic write_reg(input int code, input logic [27:0] upper);
        wr_en   = 1'b1;
        wr_data = {upper, 1'b1, 3'(code)};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (rd_data[3] && n < POLL_LIMIT) begin
            @(negedge clk);
            n++;
        end
        check(req, longint'(n < POLL_LIMIT), 1);
    endtask

    // Compare clk_out against one source at instants away from all edges.
    task automatic track(input string req, input int src);
        int bad = 0;
        #1;
        for (int k = 0; k < 60; k++) begin
            if (clk_out !== src_clk[src]) bad++;
            #2;
        end
        check(req, bad, 0);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=expired expected=finish");
        finish_run();
    end

    initial begin
        logic [27:0] up;
        up = 28'h0A5C3E1;
        repeat (20) @(negedge clk);
        // R1: reset state
        check("R1 select", rd_data[2:0], 0);
        check("R1 busy", rd_data[3], 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post-reset busy", rd_data[3], 0);
        track("R1 output follows source 0", 0);

        for (int f = 0; f < NSRC; f++) begin
            for (int t = 0; t < 8; t++) begin
                int exp_sel;
                int exp_busy;
                up = up * 28'd5 + 28'd7;
                write_reg(f, up);
                wait_idle("R10 setup");
                up = up ^ 28'h3C96A5;
                write_reg(t, up);
                exp_sel  = (t < NSRC) ? t : f;
                exp_busy = (t < NSRC && t != f) ? 1 : 0;
                if (t >= NSRC)      check("R6 busy on invalid code", rd_data[3], 0);
                else if (t == f)    check("R5 busy on same code", rd_data[3], 0);
                else                check("R4 busy after change", rd_data[3], exp_busy);
                check("R4 select readback", rd_data[2:0], exp_sel);
                check("R3 upper bits stored", rd_data[31:4], up);
                wait_idle("R10 completion");
                check("R9 busy cleared", rd_data[3], 0);
                track("R2 output follows selected source", exp_sel);
            end
        end

        // R7: a new select during a switch is dropped.
        write_reg(0, 28'h1);
        wait_idle("R10 setup");
        write_reg(2, 28'h2);
        check("R7 busy set", rd_data[3], 1);
        write_reg(3, 28'h3);
        check("R7 select held", rd_data[2:0], 2);
        check("R7 upper bits stored", rd_data[31:4], 3);
        wait_idle("R10 completion");
        check("R7 final select", rd_data[2:0], 2);
        track("R7 output on first target", 2);

        check("R8 runt phases", glitches, 0);
        check("R8 monitor active", longint'(out_edges > 100), 1);
        finish_run();
    end
endmodule